// File: doc/BRIEF.md
# Pipelined Polar-to-Cartesian Rotator

This block turns a polar sample (an unsigned magnitude and a signed phase) into a Cartesian pair using shift-and-add rotation. It accepts one sample on every clock. The result appears a fixed number of cycles later, and a valid flag travels with the data.

The rotation is fully unrolled. A front stage folds any phase outside the right half-plane back into it by a half-turn, which negates the vector. After that comes a chain of fixed iterations. Each iteration uses a wired shift and an elementary angle that is fixed at elaboration. The outputs keep the rotator's inherent gain of roughly 1.65, which the surrounding system accounts for. Typical use is in a signal generator or a coordinate converter that needs one result per clock.

Top module: `p2r_cordic`

## Requirements
- R1: The latency is ITERS+1 cycles: `out_valid` equals `in_valid` delayed by exactly ITERS+1 rising clock edges.
- R2: While `rst_n` is low, `out_valid`, `out_x` and `out_y` are zero, and samples that were in flight when reset arrived never emerge.
- R3: `in_phase` is two's complement, with value p meaning p·π/2^(PHASE_W-1). When its two top bits are equal (phase in [-π/2, π/2)), the front stage passes x = `in_mag`, y = 0 and the residual angle = `in_phase` unchanged.
- R4: When the two top bits of `in_phase` differ (01 or 10), the front stage applies a half-turn: x = -`in_mag`, y = 0, and the residual angle is `in_phase` with its top bit inverted (phase minus π, modulo 2π).
- R5: Iteration i (0 ≤ i < ITERS) takes direction +1 when the residual angle is ≥ 0 and -1 otherwise. It forms x − d·(y>>>i), y + d·(x>>>i) and residual − d·round(atan(2^-i)·2^(PHASE_W-1)/π), with arithmetic right shifts.
- R6: A new sample may be presented on every clock. Back-to-back samples are processed independently, with no interaction between them.
- R7: No gain correction is applied. The outputs approximate G·mag·cos(phase) and G·mag·sin(phase), where G = ∏ sqrt(1+2^-2i) over the iterations. The error is bounded by the last elementary angle plus truncation.
- R8: For every input, including full-scale magnitude at any phase, `out_x` and `out_y` stay within ±1.7·2^MAG_W, which fits the MAG_W+2 bit signed outputs without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a sample on the inputs this cycle |
| in_mag | input | MAG_W | Unsigned magnitude |
| in_phase | input | PHASE_W | Signed phase, full scale ±π |
| out_valid | output | 1 | Marks a result on the outputs |
| out_x | output | MAG_W+2 | Signed cosine component, scaled by G |
| out_y | output | MAG_W+2 | Signed sine component, scaled by G |

## Verification
The bound checker watches four things on every cycle. It checks the delay between `in_valid` and `out_valid`, and that `out_valid` is silent under reset. It checks the content of the folding stage for both the pass-through and half-turn cases, and it checks the output range. The bench compares every result against a behavioural model for bit-exact iteration results, covering phases on both sides of ±π/2 and at ±π. It also compares results against real-valued trigonometry within the residual-angle bound, streams samples back-to-back and with gaps, and drops in-flight data with a reset mid-stream. Only those scenarios can show that each sample's value is right and independent of its neighbours.

// File: rtl/p2r_cordic_pkg.sv
// Shared helpers for the polar-to-Cartesian rotator.
// Assumes phase words encode ±π full scale in two's complement.
package p2r_cordic_pkg;

    localparam real PI_R = 3.141592653589793;

    // Elementary angle of iteration idx in phase-word units, rounded to nearest.
    function automatic int angle_code(input int idx, input int phase_w);
        real a;
        a = $atan(1.0 / (2.0 ** idx));
        return $rtoi(a * (2.0 ** (phase_w - 1)) / PI_R + 0.5);
    endfunction

    // Signed datapath width: sign bit plus one guard bit for a gain below 2.
    function automatic int xy_width(input int mag_w);
        return mag_w + 2;
    endfunction

endpackage

// File: rtl/p2r_reduce.sv
// Front stage: folds the phase into [-π/2, π/2) by a 0 or π rotation.
// A half-turn negates the vector (y is zero here) and inverts the phase MSB.
// Assumes XW > MAG_W so the negated magnitude fits.
module p2r_reduce #(
    parameter int MAG_W   = 14,
    parameter int PHASE_W = 14,
    parameter int XW      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      v_i,
    input  logic [MAG_W-1:0]          mag_i,
    input  logic [PHASE_W-1:0]        phase_i,
    output logic                      v_o,
    output logic signed [XW-1:0]      x_o,
    output logic signed [XW-1:0]      y_o,
    output logic signed [PHASE_W-1:0] z_o
);

    logic                 flip;
    logic signed [XW-1:0] mag_s;

    assign flip  = phase_i[PHASE_W-1] ^ phase_i[PHASE_W-2];
    assign mag_s = signed'({{(XW-MAG_W){1'b0}}, mag_i});

    // Register the folded starting vector and residual angle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= flip ? -mag_s : mag_s;
            y_o <= '0;
            z_o <= {phase_i[PHASE_W-1] ^ flip, phase_i[PHASE_W-2:0]};
        end
    end

endmodule

// File: rtl/p2r_xy_stage.sv
// One vector iteration with a wired shift of IDX.
// neg_i is the sign of the residual angle feeding this iteration.
// Assumes the width XW already covers the rotator gain.
module p2r_xy_stage #(
    parameter int XW  = 16,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic                 neg_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    output logic                 v_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o
);

    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;

    assign x_sh = x_i >>> IDX;
    assign y_sh = y_i >>> IDX;

    // Rotate clockwise for a negative residual, counter-clockwise otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
        end else begin
            v_o <= v_i;
            if (neg_i) begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
            end else begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
            end
        end
    end

endmodule

// File: rtl/p2r_angle_stage.sv
// One residual-angle update with the elementary angle of iteration IDX.
// The constant is computed at elaboration, so no table exists.
module p2r_angle_stage #(
    parameter int PHASE_W = 14,
    parameter int IDX     = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [PHASE_W-1:0] z_i,
    output logic signed [PHASE_W-1:0] z_o
);

    import p2r_cordic_pkg::*;

    localparam logic signed [PHASE_W-1:0] STEP = PHASE_W'(angle_code(IDX, PHASE_W));

    // Move the residual toward zero by one elementary angle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_o <= '0;
        end else begin
            z_o <= z_i[PHASE_W-1] ? (z_i + STEP) : (z_i - STEP);
        end
    end

endmodule

// File: rtl/p2r_cordic.sv
// Unrolled, pipelined polar-to-Cartesian rotator.
// Front fold stage, then ITERS iteration stages, each registered.
// Latency ITERS+1, throughput one sample per clock; gain left uncorrected.
module p2r_cordic #(
    parameter int MAG_W   = 14,
    parameter int PHASE_W = 14,
    parameter int ITERS   = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [MAG_W-1:0]                    in_mag,
    input  logic [PHASE_W-1:0]                  in_phase,
    output logic                                out_valid,
    output logic signed [p2r_cordic_pkg::xy_width(MAG_W)-1:0] out_x,
    output logic signed [p2r_cordic_pkg::xy_width(MAG_W)-1:0] out_y
);

    import p2r_cordic_pkg::*;

    localparam int XW = xy_width(MAG_W);

    logic                      sv [0:ITERS];
    logic signed [XW-1:0]      sx [0:ITERS];
    logic signed [XW-1:0]      sy [0:ITERS];
    logic signed [PHASE_W-1:0] sz [0:ITERS-1];

    p2r_reduce #(
        .MAG_W  (MAG_W),
        .PHASE_W(PHASE_W),
        .XW     (XW)
    ) u_reduce (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_i    (in_valid),
        .mag_i  (in_mag),
        .phase_i(in_phase),
        .v_o    (sv[0]),
        .x_o    (sx[0]),
        .y_o    (sy[0]),
        .z_o    (sz[0])
    );

    for (genvar k = 0; k < ITERS; k++) begin : g_iter
        p2r_xy_stage #(
            .XW (XW),
            .IDX(k)
        ) u_xy (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (sv[k]),
            .neg_i(sz[k][PHASE_W-1]),
            .x_i  (sx[k]),
            .y_i  (sy[k]),
            .v_o  (sv[k+1]),
            .x_o  (sx[k+1]),
            .y_o  (sy[k+1])
        );
        // The last iteration needs only the sign of its residual.
        if (k < ITERS - 1) begin : g_ang
            p2r_angle_stage #(
                .PHASE_W(PHASE_W),
                .IDX    (k)
            ) u_ang (
                .clk  (clk),
                .rst_n(rst_n),
                .z_i  (sz[k]),
                .z_o  (sz[k+1])
            );
        end
    end

    assign out_valid = sv[ITERS];
    assign out_x     = sx[ITERS];
    assign out_y     = sy[ITERS];

endmodule

// File: rtl/p2r_cordic_chk.sv
// Assertion checker for p2r_cordic, attached by bind below.
// Observes the ports plus the fold-stage registers.
module p2r_cordic_chk #(
    parameter int MAG_W   = 14,
    parameter int PHASE_W = 14,
    parameter int ITERS   = 5
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 in_valid,
    input logic [MAG_W-1:0]                     in_mag,
    input logic [PHASE_W-1:0]                   in_phase,
    input logic                                 out_valid,
    input logic signed [MAG_W+1:0]              out_x,
    input logic signed [MAG_W+1:0]              out_y,
    input logic signed [MAG_W+1:0]              red_x,
    input logic signed [PHASE_W-1:0]            red_z
);

    localparam int XW  = MAG_W + 2;
    localparam int LAT = ITERS + 1;
    localparam int LIM = ((2 ** MAG_W) * 17) / 10;

    logic [LAT-1:0]       hist;
    logic signed [XW-1:0] mag_ext;

    assign mag_ext = signed'({2'b00, in_mag});

    // Independent record of in_valid over the last LAT edges.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[LAT-2:0], in_valid};
    end

    p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist[LAT-1]);

    p_reset_quiet_r2: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_fold_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase[PHASE_W-1] == in_phase[PHASE_W-2])
        |=> (red_x == $past(mag_ext)) && (red_z == signed'($past(in_phase))));

    p_fold_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase[PHASE_W-1] != in_phase[PHASE_W-2])
        |=> (red_x == -$past(mag_ext))
            && (red_z == signed'({~$past(in_phase[PHASE_W-1]), $past(in_phase[PHASE_W-2:0])})));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x <= LIM) && (out_x >= -LIM) && (out_y <= LIM) && (out_y >= -LIM));

endmodule

bind p2r_cordic p2r_cordic_chk #(
    .MAG_W  (MAG_W),
    .PHASE_W(PHASE_W),
    .ITERS  (ITERS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_mag   (in_mag),
    .in_phase (in_phase),
    .out_valid(out_valid),
    .out_x    (out_x),
    .out_y    (out_y),
    .red_x    (sx[0]),
    .red_z    (sz[0])
);

// File: tb/sim_p2r_cordic.sv
// Bench for p2r_cordic: behavioural reference model, compared every clock.
module sim_p2r_cordic;

    localparam int  MAG_W   = 14;
    localparam int  PHASE_W = 14;
    localparam int  ITERS   = 5;
    localparam int  XW      = MAG_W + 2;
    localparam int  LAT     = ITERS + 1;
    localparam real PI_R    = 3.141592653589793;
    localparam int  LIM     = ((2 ** MAG_W) * 17) / 10;

    logic                 clk      = 1'b0;
    logic                 rst_n    = 1'b0;
    logic                 in_valid = 1'b0;
    logic [MAG_W-1:0]     in_mag   = '0;
    logic [PHASE_W-1:0]   in_phase = '0;
    logic                 out_valid;
    logic signed [XW-1:0] out_x;
    logic signed [XW-1:0] out_y;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    v;
        int    ex;
        int    ey;
        int    mag;
        int    ph;
        bit    flip;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    p2r_cordic #(
        .MAG_W  (MAG_W),
        .PHASE_W(PHASE_W),
        .ITERS  (ITERS)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_mag   (in_mag),
        .in_phase (in_phase),
        .out_valid(out_valid),
        .out_x    (out_x),
        .out_y    (out_y)
    );

    function automatic int as_signed(input int u);
        return (u >= 2 ** (PHASE_W - 1)) ? u - 2 ** PHASE_W : u;
    endfunction

    // Reference: fold by half-turn, then ITERS shift-add iterations (R3, R4, R5).
    function automatic void model(input int mag, input int u, output int ex,
                                  output int ey, output bit flip);
        int x, y, z, nx, ny, e, top;
        top  = (u >> (PHASE_W - 2)) & 3;
        flip = (top == 1) || (top == 2);
        x    = flip ? -mag : mag;
        y    = 0;
        z    = as_signed(flip ? (u ^ (1 << (PHASE_W - 1))) : u);
        for (int i = 0; i < ITERS; i++) begin
            e = $rtoi($atan(1.0 / (2.0 ** i)) * (2.0 ** (PHASE_W - 1)) / PI_R + 0.5);
            if (z < 0) begin
                nx = x + (y >>> i);
                ny = y - (x >>> i);
                z  = z + e;
            end else begin
                nx = x - (y >>> i);
                ny = y + (x >>> i);
                z  = z - e;
            end
            x = nx;
            y = ny;
        end
        ex = x;
        ey = y;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic check_near(input string req, input string what, input int act,
                              input real expv, input real tol);
        real diff;
        checks++;
        diff = act - expv;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0.1f (tol %0.1f)", req, what, act, expv, tol);
        end
    endtask

    // Compare outputs with the entry pushed LAT negedges ago.
    task automatic compare_out();
        exp_t e;
        real  gain, th, tol;
        int   ax, ay;
        if (q.size() == LAT) begin
            e = q.pop_front();
            check_eq("R1", "out_valid", int'(out_valid), int'(e.v));
            if (e.v) begin
                ax = int'(out_x);
                ay = int'(out_y);
                check_eq({e.flip ? "R4" : "R3", " R5 ", e.tag}, "out_x", ax, e.ex);
                check_eq({e.flip ? "R4" : "R3", " R5 ", e.tag}, "out_y", ay, e.ey);
                check_eq("R8", "x within range", int'(ax <= LIM && ax >= -LIM), 1);
                check_eq("R8", "y within range", int'(ay <= LIM && ay >= -LIM), 1);
                if (e.mag >= 1000) begin
                    gain = 1.0;
                    for (int i = 0; i < ITERS; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2 * i));
                    th  = e.ph * PI_R / (2.0 ** (PHASE_W - 1));
                    tol = gain * e.mag * $atan(2.0 ** (-(ITERS - 1))) * 1.05 + 2.0 * ITERS;
                    check_near("R7", "x vs G*r*cos", ax, gain * e.mag * $cos(th), tol);
                    check_near("R7", "y vs G*r*sin", ay, gain * e.mag * $sin(th), tol);
                end
            end
        end
    endtask

    // One clock: check outputs, then drive the next sample.
    task automatic step(input bit v, input int mag, input int ph, input string tag);
        exp_t e;
        int   u;
        @(negedge clk);
        compare_out();
        u        = ph & ((1 << PHASE_W) - 1);
        in_valid = v;
        in_mag   = mag[MAG_W-1:0];
        in_phase = u[PHASE_W-1:0];
        e.v      = v;
        e.mag    = mag;
        e.ph     = as_signed(u);
        e.tag    = tag;
        model(mag, u, e.ex, e.ey, e.flip);
        q.push_back(e);
    endtask

    // Hold reset for n cycles, checking quiet outputs (R2), then release.
    task automatic do_reset(input int n);
        exp_t idle;
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        q.delete();
        repeat (n) begin
            @(negedge clk);
            check_eq("R2", "out_valid in reset", int'(out_valid), 0);
            check_eq("R2", "out_x in reset", int'(out_x), 0);
            check_eq("R2", "out_y in reset", int'(out_y), 0);
        end
        rst_n    = 1'b1;
        idle.v   = 1'b0;
        idle.ex  = 0;
        idle.ey  = 0;
        idle.mag = 0;
        idle.ph  = 0;
        idle.flip = 1'b0;
        idle.tag = "";
        for (int i = 0; i < LAT; i++) q.push_back(idle);
    endtask

    initial begin
        int ph_list[12];
        ph_list = '{0, 1, -1, 2047, 4095, 4096, -4096, -4097, 8191, -8192, 6000, -6000};
        do_reset(4);
        // R6: back-to-back directed phases at several magnitudes.
        foreach (ph_list[i]) step(1'b1, 16383, ph_list[i], "R6");
        foreach (ph_list[i]) step(1'b1, 1000, ph_list[i], "R6");
        foreach (ph_list[i]) step(1'b1, i % 2, ph_list[i], "R6");
        // R1: gaps in the valid stream.
        for (int k = 0; k < 12; k++) step(k % 3 != 0, 3000 + k * 700, k * 1300 - 7000, "R1");
        // R8: full-scale sweep over the whole circle.
        for (int k = 0; k < 64; k++) step(1'b1, 16383, -8192 + k * 256, "R8");
        for (int k = 0; k < 64; k++) step(1'b1, 5000 + k * 50, 8191 - k * 257, "R6");
        // R2: reset with samples in flight; they must not emerge.
        for (int k = 0; k < 4; k++) step(1'b1, 9000, k * 3000, "R6");
        do_reset(2);
        for (int k = 0; k < 8; k++) step(1'b1, 12000, 4096 - k * 1024, "R6");
        repeat (LAT + 2) step(1'b0, 0, 0, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule